// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the data side of a small 16-bit processor whose sequencing is done elsewhere. It holds the program counter, the instruction register, a sixteen-entry register file with two read ports and one write port, a four-operation ALU, the memory address selector, a 256-word unified program and data RAM, and a registered output port. A separate control state machine drives every strobe and select code each cycle and reads back the instruction word to decide its next state.

Instruction words place the opcode in bits 15:12, the first register index in bits 11:8 and the second in bits 7:4. The low byte serves both as a direct memory address and as an immediate. The ALU can pass either operand unchanged. This lets one result path feed the register file, the memory write data and the zero test for conditional jumps. A preload write port fills the RAM before a program runs.

Top module: `mcp_datapath`

## Requirements
- R1: Synchronous reset clears the program counter, the instruction register, all sixteen registers, the RAM read-data register and the output port to zero.
- R2: The ALU select code gives, modulo 2^16: 10 = read port 1 plus read port 2, 11 = read port 1 minus read port 2, 00 = read port 1 unchanged, 01 = read port 2 unchanged.
- R3: On an edge with the register write enable high, the register at the write index takes the source picked by the write select: 00 = ALU result, 01 = RAM read data, 10 = instruction bits 7:0 zero-extended to 16 bits. With the write enable low, no register changes.
- R4: The RAM address select picks 10 = program counter, 01 = instruction bits 7:0, 00 = low 8 bits of read port 1.
- R5: On an edge with the memory write enable high, the RAM word at the selected address takes the ALU result. On an edge with the memory read enable high, the RAM read-data register takes the word at the selected address, and it holds otherwise.
- R6: The instruction register loads the RAM read data only on an edge where both its load strobe and the memory read enable are high.
- R7: The program counter clears when the clear strobe is high. Otherwise it loads instruction bits 7:0 when the jump enable is high and read port 1 holds zero. Otherwise it increments when the increment strobe is high. Otherwise it holds.
- R8: The output port captures the RAM read data on an edge with the output strobe high and holds its value otherwise.
- R9: Each read port register loads the addressed register on an edge with its own enable high and holds its value while the enable is low, even if its index changes.
- R10: The preload port writes its data into the RAM on an edge with its enable high. It wins over a datapath write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_clr | input | 1 | Clear program counter |
| pc_inc | input | 1 | Increment program counter |
| jmp_en | input | 1 | Jump if read port 1 is zero |
| ir_ld | input | 1 | Instruction register load strobe |
| rf_wsel | input | 2 | Register write source select |
| rf_we | input | 1 | Register write enable |
| rf_waddr | input | 4 | Register write index |
| rf_re1 | input | 1 | Read port 1 enable |
| rf_raddr1 | input | 4 | Read port 1 index |
| rf_re2 | input | 1 | Read port 2 enable |
| rf_raddr2 | input | 4 | Read port 2 index |
| alu_sel | input | 2 | ALU operation select |
| mem_asel | input | 2 | RAM address select |
| mem_re | input | 1 | RAM read enable |
| mem_we | input | 1 | RAM write enable |
| out_en | input | 1 | Output port capture strobe |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 8 | Preload address |
| pre_data | input | 16 | Preload data |
| ir_word | output | 16 | Instruction register contents |
| pc_value | output | 8 | Program counter |
| data_out | output | 16 | Output port |

## Verification
A register holding a wrong value stays invisible until it is read onto a port, routed through the ALU into RAM and brought back through the read register to the output port. That path takes four edges from the read strobe, so every register check walks it. A wrong instruction register shows at once on the instruction word, and a wrong jump decision shows on the program counter on the edge after the strobe. A wrong read-port hold or address selection corrupts the next RAM write, and it surfaces only when that word is read back two edges later.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

  typedef enum logic [1:0] {
    ALU_PASS_A = 2'b00,
    ALU_PASS_B = 2'b01,
    ALU_ADD    = 2'b10,
    ALU_SUB    = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    WSRC_ALU  = 2'b00,
    WSRC_MEM  = 2'b01,
    WSRC_IMM  = 2'b10,
    WSRC_NONE = 2'b11
  } wsrc_e;

  typedef enum logic [1:0] {
    ASEL_REG  = 2'b00,
    ASEL_DIR  = 2'b01,
    ASEL_PC   = 2'b10,
    ASEL_RSVD = 2'b11
  } asel_e;

endpackage

// File: rtl/mcp_alu.sv
module mcp_alu
  import mcp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (alu_op_e'(op))
      ALU_PASS_A: y = a;
      ALU_PASS_B: y = b;
      ALU_ADD:    y = a + b;
      ALU_SUB:    y = a - b;
      default:    y = a;
    endcase
  end

endmodule

// File: rtl/mcp_pc.sv
module mcp_pc #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  input  logic              jmp_en,
  input  logic              zero,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);

  logic take_jump;
  assign take_jump = jmp_en & zero;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pc <= '0;
    end else if (take_jump) begin
      pc <= target;
    end else if (inc) begin
      pc <= pc + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/mcp_regfile.sv
module mcp_regfile #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re1,
  input  logic [IDX_W-1:0]  raddr1,
  input  logic              re2,
  input  logic [IDX_W-1:0]  raddr2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] regs [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          regs[g] <= '0;
        end else if (we && (waddr == IDX_W'(g))) begin
          regs[g] <= wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd1 <= '0;
      rd2 <= '0;
    end else begin
      if (re1) rd1 <= regs[raddr1];
      if (re2) rd2 <= regs[raddr2];
    end
  end

endmodule

// File: rtl/mcp_ram.sv
module mcp_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_go;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  always_comb begin
    wr_go   = pre_we | we;
    wr_addr = pre_we ? pre_addr : addr;
    wr_data = pre_we ? pre_data : wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/mcp_datapath.sv
module mcp_datapath
  import mcp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_clr,
  input  logic              pc_inc,
  input  logic              jmp_en,
  input  logic              ir_ld,
  input  logic [1:0]        rf_wsel,
  input  logic              rf_we,
  input  logic [IDX_W-1:0]  rf_waddr,
  input  logic              rf_re1,
  input  logic [IDX_W-1:0]  rf_raddr1,
  input  logic              rf_re2,
  input  logic [IDX_W-1:0]  rf_raddr2,
  input  logic [1:0]        alu_sel,
  input  logic [1:0]        mem_asel,
  input  logic              mem_re,
  input  logic              mem_we,
  input  logic              out_en,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  output logic [DATA_W-1:0] ir_word,
  output logic [ADDR_W-1:0] pc_value,
  output logic [DATA_W-1:0] data_out
);

  localparam int EXT_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] rd1_q;
  logic [DATA_W-1:0] rd2_q;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] rf_wdata;
  logic [DATA_W-1:0] imm_ext;
  logic [ADDR_W-1:0] mem_addr;
  logic [ADDR_W-1:0] low_field;

  assign low_field = ir_word[ADDR_W-1:0];
  assign imm_ext   = {{EXT_W{1'b0}}, low_field};

  always_comb begin
    unique case (wsrc_e'(rf_wsel))
      WSRC_ALU: rf_wdata = alu_y;
      WSRC_MEM: rf_wdata = mem_rdata;
      WSRC_IMM: rf_wdata = imm_ext;
      default:  rf_wdata = '0;
    endcase
  end

  always_comb begin
    unique case (asel_e'(mem_asel))
      ASEL_REG: mem_addr = rd1_q[ADDR_W-1:0];
      ASEL_DIR: mem_addr = low_field;
      ASEL_PC:  mem_addr = pc_value;
      default:  mem_addr = pc_value;
    endcase
  end

  mcp_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .clr    (pc_clr),
    .inc    (pc_inc),
    .jmp_en (jmp_en),
    .zero   (rd1_q == '0),
    .target (low_field),
    .pc     (pc_value)
  );

  mcp_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (rf_wdata),
    .re1    (rf_re1),
    .raddr1 (rf_raddr1),
    .re2    (rf_re2),
    .raddr2 (rf_raddr2),
    .rd1    (rd1_q),
    .rd2    (rd2_q)
  );

  mcp_alu #(.DATA_W(DATA_W)) u_alu (
    .op (alu_sel),
    .a  (rd1_q),
    .b  (rd2_q),
    .y  (alu_y)
  );

  mcp_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk      (clk),
    .rst      (rst),
    .pre_we   (pre_we),
    .pre_addr (pre_addr),
    .pre_data (pre_data),
    .we       (mem_we),
    .re       (mem_re),
    .addr     (mem_addr),
    .wdata    (alu_y),
    .rdata    (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_word <= '0;
    end else if (ir_ld && mem_re) begin
      ir_word <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
    end else if (out_en) begin
      data_out <= mem_rdata;
    end
  end

endmodule

// File: rtl/mcp_datapath_chk.sv
module mcp_datapath_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pc_clr,
  input logic              pc_inc,
  input logic              jmp_en,
  input logic              ir_ld,
  input logic              mem_re,
  input logic              out_en,
  input logic [DATA_W-1:0] rd1,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] ir_word,
  input logic [ADDR_W-1:0] pc_value,
  input logic [DATA_W-1:0] data_out
);

  // R1: one reset edge empties every visible register
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pc_value == '0 && ir_word == '0 && data_out == '0));

  // R6: no load unless both strobes are high
  assert_ir_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(ir_ld && mem_re) |=> $stable(ir_word));

  // R6: both strobes high capture the read data
  assert_ir_load_R6: assert property (@(posedge clk) disable iff (rst)
    (ir_ld && mem_re) |=> ir_word == $past(rdata));

  // R7: clear has top priority
  assert_pc_clear_R7: assert property (@(posedge clk) disable iff (rst)
    pc_clr |=> pc_value == '0);

  // R7: taken jump loads the low field and beats increment
  assert_pc_jump_R7: assert property (@(posedge clk) disable iff (rst)
    (jmp_en && !pc_clr && rd1 == '0) |=> pc_value == $past(ir_word[ADDR_W-1:0]));

  // R7: increment when no clear and no taken jump
  assert_pc_inc_R7: assert property (@(posedge clk) disable iff (rst)
    (pc_inc && !pc_clr && !(jmp_en && rd1 == '0)) |=> pc_value == $past(pc_value) + ADDR_W'(1));

  // R8: capture and hold of the output port
  assert_out_capture_R8: assert property (@(posedge clk) disable iff (rst)
    out_en |=> data_out == $past(rdata));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> $stable(data_out));

endmodule

bind mcp_datapath mcp_datapath_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc_clr   (pc_clr),
  .pc_inc   (pc_inc),
  .jmp_en   (jmp_en),
  .ir_ld    (ir_ld),
  .mem_re   (mem_re),
  .out_en   (out_en),
  .rd1      (rd1_q),
  .rdata    (mem_rdata),
  .ir_word  (ir_word),
  .pc_value (pc_value),
  .data_out (data_out)
);

// File: tb/sim_mcp_datapath.sv
module sim_mcp_datapath;

  logic        clk = 1'b0;
  logic        rst;
  logic        pc_clr, pc_inc, jmp_en, ir_ld;
  logic [1:0]  rf_wsel;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic        rf_re1;
  logic [3:0]  rf_raddr1;
  logic        rf_re2;
  logic [3:0]  rf_raddr2;
  logic [1:0]  alu_sel, mem_asel;
  logic        mem_re, mem_we, out_en;
  logic        pre_we;
  logic [7:0]  pre_addr;
  logic [15:0] pre_data;
  logic [15:0] ir_word;
  logic [7:0]  pc_value;
  logic [15:0] data_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] got;

  always #5 clk = ~clk;

  mcp_datapath u0 (
    .clk(clk), .rst(rst), .pc_clr(pc_clr), .pc_inc(pc_inc), .jmp_en(jmp_en),
    .ir_ld(ir_ld), .rf_wsel(rf_wsel), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_re1(rf_re1), .rf_raddr1(rf_raddr1), .rf_re2(rf_re2), .rf_raddr2(rf_raddr2),
    .alu_sel(alu_sel), .mem_asel(mem_asel), .mem_re(mem_re), .mem_we(mem_we),
    .out_en(out_en), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .ir_word(ir_word), .pc_value(pc_value), .data_out(data_out)
  );

  // {operand a, operand b, ALU code, expected}
  localparam logic [49:0] ALU_VEC [8] = '{
    {16'h1234, 16'h0101, 2'b10, 16'h1335},
    {16'hFFFF, 16'h0002, 2'b10, 16'h0001},
    {16'h8000, 16'h8000, 2'b10, 16'h0000},
    {16'h5000, 16'h1000, 2'b11, 16'h4000},
    {16'h0001, 16'h0002, 2'b11, 16'hFFFF},
    {16'h0000, 16'h0000, 2'b11, 16'h0000},
    {16'hABCD, 16'h1111, 2'b00, 16'hABCD},
    {16'hABCD, 16'h1111, 2'b01, 16'h1111}
  };

  task automatic idle();
    pc_clr = 0; pc_inc = 0; jmp_en = 0; ir_ld = 0;
    rf_wsel = 2'b00; rf_we = 0; rf_waddr = 0;
    rf_re1 = 0; rf_raddr1 = 0; rf_re2 = 0; rf_raddr2 = 0;
    alu_sel = 2'b00; mem_asel = 2'b10; mem_re = 0; mem_we = 0; out_en = 0;
    pre_we = 0; pre_addr = 0; pre_data = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic preload(logic [7:0] a, logic [15:0] d);
    pre_we = 1; pre_addr = a; pre_data = d;
    tick();
  endtask

  // uses RAM word at the program counter as scratch
  task automatic load_reg(logic [3:0] r, logic [15:0] v);
    preload(pc_value, v);
    mem_asel = 2'b10; mem_re = 1;
    tick();
    rf_wsel = 2'b01; rf_we = 1; rf_waddr = r;
    tick();
  endtask

  task automatic show_reg(logic [3:0] r, output logic [15:0] v);
    rf_re1 = 1; rf_raddr1 = r;
    tick();
    alu_sel = 2'b00; mem_asel = 2'b10; mem_we = 1;
    tick();
    mem_asel = 2'b10; mem_re = 1;
    tick();
    out_en = 1;
    tick();
    v = data_out;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    tick();
    rst = 0;

    // R1 reset state
    check("R1 pc", {8'h00, pc_value}, 16'h0000);
    check("R1 ir", ir_word, 16'h0000);
    check("R1 out", data_out, 16'h0000);

    // R2 / R3 ALU table walk: R1 op R2 -> R3
    foreach (ALU_VEC[i]) begin
      load_reg(4'd1, ALU_VEC[i][49:34]);
      load_reg(4'd2, ALU_VEC[i][33:18]);
      rf_re1 = 1; rf_raddr1 = 4'd1; rf_re2 = 1; rf_raddr2 = 4'd2;
      tick();
      alu_sel = ALU_VEC[i][17:16]; rf_wsel = 2'b00; rf_we = 1; rf_waddr = 4'd3;
      tick();
      show_reg(4'd3, got);
      check("R2 alu op", got, ALU_VEC[i][15:0]);
    end

    // R6 / R10 fetch of a preloaded instruction
    preload(8'h00, 16'h61A5);
    mem_asel = 2'b10; mem_re = 1; ir_ld = 1;
    tick();
    mem_asel = 2'b10; mem_re = 1; ir_ld = 1;
    tick();
    check("R6 R10 fetch", ir_word, 16'h61A5);

    // R6 load strobe without read enable is ignored
    preload(8'h00, 16'h7777);
    mem_asel = 2'b10; mem_re = 1;
    tick();
    ir_ld = 1;
    tick();
    check("R6 no load without read", ir_word, 16'h61A5);

    // R3 immediate, zero-extended
    rf_wsel = 2'b10; rf_we = 1; rf_waddr = 4'd4;
    tick();
    show_reg(4'd4, got);
    check("R3 immediate", got, 16'h00A5);

    // R3 write enable low changes nothing
    rf_wsel = 2'b10; rf_we = 0; rf_waddr = 4'd5;
    tick();
    show_reg(4'd5, got);
    check("R3 no write", got, 16'h0000);

    // R4 direct address from instruction low byte
    preload(8'hA5, 16'h1234);
    mem_asel = 2'b01; mem_re = 1;
    tick();
    out_en = 1;
    tick();
    check("R4 direct read", data_out, 16'h1234);

    // R8 hold while strobe low
    preload(8'h00, 16'h5555);
    mem_asel = 2'b10; mem_re = 1;
    tick();
    tick();
    check("R8 hold", data_out, 16'h1234);

    // R4 / R5 indirect store: mem[R5 low byte] <= R6
    load_reg(4'd5, 16'h1240);
    load_reg(4'd6, 16'hBEEF);
    rf_re1 = 1; rf_raddr1 = 4'd5; rf_re2 = 1; rf_raddr2 = 4'd6;
    tick();
    alu_sel = 2'b01; mem_asel = 2'b00; mem_we = 1;
    tick();
    mem_asel = 2'b00; mem_re = 1;
    tick();
    out_en = 1;
    tick();
    check("R4 R5 indirect store", data_out, 16'hBEEF);

    // R9 read port holds while its enable is low
    load_reg(4'd7, 16'h0ABC);
    rf_re1 = 1; rf_raddr1 = 4'd7;
    tick();
    rf_raddr1 = 4'd5; alu_sel = 2'b00; mem_asel = 2'b10; mem_we = 1;
    tick();
    mem_asel = 2'b10; mem_re = 1;
    tick();
    out_en = 1;
    tick();
    check("R9 port hold", data_out, 16'h0ABC);

    // R10 preload wins over a datapath write at the same address
    mem_asel = 2'b10; mem_we = 1; alu_sel = 2'b00;
    pre_we = 1; pre_addr = pc_value; pre_data = 16'h4242;
    tick();
    mem_asel = 2'b10; mem_re = 1;
    tick();
    out_en = 1;
    tick();
    check("R10 preload priority", data_out, 16'h4242);

    // R7 program counter (read port 1 holds 0x0ABC, non-zero)
    pc_inc = 1;
    tick();
    check("R7 increment", {8'h00, pc_value}, 16'h0001);
    jmp_en = 1; pc_inc = 1;
    tick();
    check("R7 untaken jump increments", {8'h00, pc_value}, 16'h0002);
    jmp_en = 1;
    tick();
    check("R7 untaken jump holds", {8'h00, pc_value}, 16'h0002);
    rf_re1 = 1; rf_raddr1 = 4'd0;
    tick();
    jmp_en = 1; pc_inc = 1;
    tick();
    check("R7 taken jump", {8'h00, pc_value}, 16'h00A5);
    pc_clr = 1; jmp_en = 1; pc_inc = 1;
    tick();
    check("R7 clear wins", {8'h00, pc_value}, 16'h0000);

    // R1 reset in mid-run clears registers too
    rst = 1;
    tick();
    rst = 0;
    check("R1 ir after reset", ir_word, 16'h0000);
    check("R1 out after reset", data_out, 16'h0000);
    show_reg(4'd4, got);
    check("R1 register cleared", got, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule